// File: doc/BRIEF.md
# Watermark-Arbitrated Request Packer

This block sits on the processor side of a serial memory link and serves one destination buffer scheduler. Read and write requests arrive on two separate valid/ready inputs and are held in two queues. Write payload arrives on a third input as 64-bit words. The block repeatedly chooses a request class and emits a packet on a 64-bit valid/ready output stream that stands in for the link. A packet is one header word followed by a group of messages of that one class. Each write message is followed by its payload words.

Reads normally take precedence. When the write queue grows past a high watermark, the block switches to draining writes and keeps choosing them until write occupancy falls under a low watermark. The gap between the two thresholds stops the choice from flipping back and forth. The next header is formed in a register as soon as a queue holds something, so it is already waiting when the link frees up.

Top module: `req_packer`

## Requirements
- R1: After reset, `pkt_valid` is low and `rd_ready`, `wr_ready` and `wd_ready` are high.
- R2: Each request queue holds `Q_DEPTH` (64) entries. Its ready output is low while it is full, and a full queue does not block the other queue.
- R3: While not draining writes, a packet start picks reads whenever the read queue is non-empty. It picks writes only when no read is queued.
- R4: Write draining turns on one cycle after write occupancy exceeds `HI_WM` (48). While draining, no read packet starts.
- R5: Draining turns off one cycle after write occupancy drops below `LO_WM` (16). Between the two thresholds the draining state is held, and read priority returns once draining is off.
- R6: Header layout: bits [1:0] carry the type (0 read, 1 write, 2 reserved for returns); bits [5:2] carry the message count; bits [9:6] carry `DEST_ID`; bits [63:10] are zero.
- R7: The header count equals the selected queue's occupancy at packet start, capped at `MAX_REQ` (8). It lies between 1 and 8, and exactly that many messages follow.
- R8: Message layout: address in bits [39:0], granularity in bits [43:40], zero above.
- R9: A write message with granularity g is followed by exactly g payload words, taken from the payload queue in arrival order. Granularity 0 carries no payload.
- R10: While `pkt_valid` is high and `pkt_ready` is low, `pkt_data` and `pkt_last` hold. `pkt_last` is high only on the final word of a packet.
- R11: Every accepted request appears exactly once, and requests of the same class keep their arrival order.
- R12: With the link stalled, a header appears on the output two cycles after the first request is accepted into an empty block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read queue has room |
| rd_addr | input | ADDR_W (40) | Read address |
| rd_gran | input | GRAN_W (4) | Read size in 8-byte units |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write queue has room |
| wr_addr | input | ADDR_W (40) | Write address |
| wr_gran | input | GRAN_W (4) | Write size in 8-byte units |
| wd_valid | input | 1 | Write payload word offered |
| wd_ready | output | 1 | Payload queue has room |
| wd_data | input | 64 | Write payload word |
| pkt_valid | output | 1 | Link word valid |
| pkt_ready | input | 1 | Link accepts word |
| pkt_data | output | 64 | Header, message or payload word |
| pkt_last | output | 1 | Final word of the packet |

## Verification
Directed runs load the queues while the link is stalled, then release it, so the sequence of packet types and counts is fully known. One mix stays under the high watermark and shows read precedence. One overshoots the high watermark and must give five full write packets, then a read packet, then the remaining writes; this separates the hysteresis from a single-threshold policy. Filling the read queue to its limit exposes both backpressure and the cap on packet size. A long random mix with a randomly stalling link and granularities including zero checks, against bench-side queues, that every message and payload word appears once and in order, and that each header count matches the messages that follow it.

// File: rtl/pkr_pkg.sv
`timescale 1ns/1ps
package pkr_pkg;
    typedef enum logic [1:0] {
        PK_RD  = 2'd0,
        PK_WR  = 2'd1,
        PK_RET = 2'd2
    } pkt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_MSG,
        ST_DATA
    } pk_state_e;
endpackage

// File: rtl/pkr_fifo.sv
`timescale 1ns/1ps
module pkr_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [W-1:0]                   din,
    input  logic                           pop,
    output logic [W-1:0]                   dout,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fptr_t;

    fptr_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = (s_q.wp == LAST_A) ? '0 : s_q.wp + AW'(1);
        if (pop)  s_d.rp = (s_q.rp == LAST_A) ? '0 : s_q.rp + AW'(1);
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[s_q.wp] <= din;
    end

    assign dout  = mem[s_q.rp];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == FULL_C);
    assign empty = (s_q.cnt == '0);

    // R2
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R11
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_C);
endmodule

// File: rtl/pkr_drain_sel.sv
`timescale 1ns/1ps
module pkr_drain_sel #(
    parameter int unsigned CW    = 7,
    parameter int unsigned HI_WM = 48,
    parameter int unsigned LO_WM = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wr_occ,
    output logic          drain
);
    localparam logic [CW-1:0] HI_C = CW'(HI_WM);
    localparam logic [CW-1:0] LO_C = CW'(LO_WM);

    logic drain_d, drain_q;

    always_comb begin
        drain_d = drain_q;
        if (wr_occ > HI_C)      drain_d = 1'b1;
        else if (wr_occ < LO_C) drain_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drain_q <= 1'b0;
        else        drain_q <= drain_d;
    end

    assign drain = drain_q;

    // R4
    drain_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_occ > HI_C) |=> drain);
    // R5
    drain_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_occ < LO_C) |=> !drain);
    // R5
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_occ >= LO_C && wr_occ <= HI_C && drain) |=> drain);
endmodule

// File: rtl/req_packer.sv
`timescale 1ns/1ps
module req_packer
    import pkr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 40,
    parameter int unsigned GRAN_W   = 4,
    parameter int unsigned DEST_W   = 4,
    parameter logic [DEST_W-1:0] DEST_ID = DEST_W'(5),
    parameter int unsigned Q_DEPTH  = 64,
    parameter int unsigned WD_DEPTH = 256,
    parameter int unsigned MAX_REQ  = 8,
    parameter int unsigned HI_WM    = 48,
    parameter int unsigned LO_WM    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [GRAN_W-1:0] rd_gran,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [GRAN_W-1:0] wr_gran,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [63:0]       wd_data,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [63:0]       pkt_data,
    output logic              pkt_last
);
    localparam int unsigned MSG_W   = ADDR_W + GRAN_W;
    localparam int unsigned QCW     = $clog2(Q_DEPTH + 1);
    localparam int unsigned DCW     = $clog2(WD_DEPTH + 1);
    localparam int unsigned CNT_W   = $clog2(MAX_REQ + 1);
    localparam int unsigned HDR_PAD = 64 - 2 - CNT_W - DEST_W;
    localparam int unsigned MSG_PAD = 64 - MSG_W;
    localparam logic [QCW-1:0]   MAXQ = QCW'(MAX_REQ);
    localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_REQ);
    localparam logic [DCW-1:0]   WDFULL = DCW'(WD_DEPTH);

    typedef struct packed {
        pk_state_e         st;
        logic              is_wr;
        logic [CNT_W-1:0]  left;
        logic [GRAN_W-1:0] dleft;
        logic [63:0]       hdr;
    } ctl_t;

    localparam ctl_t CTL_RST = '{ST_IDLE, 1'b0, '0, '0, '0};

    ctl_t c_d, c_q;

    logic             rd_full, rd_empty, rd_pop, rd_push;
    logic             wr_full, wr_empty, wr_pop, wr_push;
    logic             wd_full, wd_empty, wd_pop, wd_push;
    logic [QCW-1:0]   rd_cnt, wr_cnt;
    logic [DCW-1:0]   wd_cnt;
    logic [MSG_W-1:0] rd_dout, wr_dout;
    logic [63:0]      wd_dout;
    logic             drain;

    assign rd_ready = !rd_full;
    assign wr_ready = !wr_full;
    assign wd_ready = !wd_full;
    assign rd_push  = rd_valid && !rd_full;
    assign wr_push  = wr_valid && !wr_full;
    assign wd_push  = wd_valid && !wd_full;

    pkr_fifo #(.W(MSG_W), .DEPTH(Q_DEPTH)) u_rdq (
        .clk(clk), .rst_n(rst_n), .push(rd_push), .din({rd_gran, rd_addr}),
        .pop(rd_pop), .dout(rd_dout), .full(rd_full), .empty(rd_empty),
        .count(rd_cnt));

    pkr_fifo #(.W(MSG_W), .DEPTH(Q_DEPTH)) u_wrq (
        .clk(clk), .rst_n(rst_n), .push(wr_push), .din({wr_gran, wr_addr}),
        .pop(wr_pop), .dout(wr_dout), .full(wr_full), .empty(wr_empty),
        .count(wr_cnt));

    pkr_fifo #(.W(64), .DEPTH(WD_DEPTH)) u_wdq (
        .clk(clk), .rst_n(rst_n), .push(wd_push), .din(wd_data),
        .pop(wd_pop), .dout(wd_dout), .full(wd_full), .empty(wd_empty),
        .count(wd_cnt));

    pkr_drain_sel #(.CW(QCW), .HI_WM(HI_WM), .LO_WM(LO_WM)) u_sel (
        .clk(clk), .rst_n(rst_n), .wr_occ(wr_cnt), .drain(drain));

    logic [MSG_W-1:0]  head;
    logic [GRAN_W-1:0] head_gran;
    logic              pick_wr, pick_any, msg_last, has_data;
    logic [QCW-1:0]    occ;
    logic [CNT_W-1:0]  take;
    logic [1:0]        kind_bits;

    always_comb begin
        c_d       = c_q;
        rd_pop    = 1'b0;
        wr_pop    = 1'b0;
        wd_pop    = 1'b0;
        pkt_valid = 1'b0;
        pkt_data  = '0;
        pkt_last  = 1'b0;

        head      = c_q.is_wr ? wr_dout : rd_dout;
        head_gran = head[ADDR_W +: GRAN_W];
        msg_last  = (c_q.left == CNT_W'(1));
        has_data  = c_q.is_wr && (head_gran != '0);

        pick_wr   = !wr_empty && (drain || rd_empty);
        pick_any  = !rd_empty || !wr_empty;
        occ       = pick_wr ? wr_cnt : rd_cnt;
        take      = (occ > MAXQ) ? MAXC : occ[CNT_W-1:0];
        kind_bits = pick_wr ? 2'(PK_WR) : 2'(PK_RD);

        unique case (c_q.st)
            ST_IDLE: begin
                if (pick_any) begin
                    c_d.st    = ST_HDR;
                    c_d.is_wr = pick_wr;
                    c_d.left  = take;
                    c_d.hdr   = {{HDR_PAD{1'b0}}, DEST_ID, take, kind_bits};
                end
            end
            ST_HDR: begin
                pkt_valid = 1'b1;
                pkt_data  = c_q.hdr;
                if (pkt_ready) c_d.st = ST_MSG;
            end
            ST_MSG: begin
                pkt_valid = 1'b1;
                pkt_data  = {{MSG_PAD{1'b0}}, head};
                pkt_last  = msg_last && !has_data;
                if (pkt_ready) begin
                    rd_pop   = !c_q.is_wr;
                    wr_pop   = c_q.is_wr;
                    c_d.left = c_q.left - CNT_W'(1);
                    if (has_data) begin
                        c_d.st    = ST_DATA;
                        c_d.dleft = head_gran;
                    end else if (msg_last) begin
                        c_d.st = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                pkt_valid = !wd_empty;
                pkt_data  = wd_dout;
                pkt_last  = (c_q.left == '0) && (c_q.dleft == GRAN_W'(1));
                if (!wd_empty && pkt_ready) begin
                    wd_pop    = 1'b1;
                    c_d.dleft = c_q.dleft - GRAN_W'(1);
                    if (c_q.dleft == GRAN_W'(1))
                        c_d.st = (c_q.left == '0) ? ST_IDLE : ST_MSG;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= CTL_RST;
        else        c_q <= c_d;
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));
    // R7
    hdr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_HDR) |-> (c_q.hdr[2 +: CNT_W] >= CNT_W'(1) && c_q.hdr[2 +: CNT_W] <= MAXC));
    // R4
    no_read_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE && c_d.st == ST_HDR && !c_d.is_wr) |-> !drain);
    // R12
    prebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE && (!rd_empty || !wr_empty)) |=> pkt_valid);
    // R9
    wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_pop |-> (wd_cnt != '0 && wd_cnt <= WDFULL));
endmodule

// File: tb/req_packer_tb.sv
`timescale 1ns/1ps
module req_packer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0, wr_valid = 1'b0, wd_valid = 1'b0;
    logic        rd_ready, wr_ready, wd_ready;
    logic [39:0] rd_addr = '0, wr_addr = '0;
    logic [3:0]  rd_gran = '0, wr_gran = '0;
    logic [63:0] wd_data = '0;
    logic        pkt_valid, pkt_last;
    logic        pkt_ready = 1'b0;
    logic [63:0] pkt_data;

    int checks = 0;
    int errors = 0;
    int link_mode = 0;   // 0 stalled, 1 open, 2 random

    logic [63:0] exp_rd[$];
    logic [63:0] exp_wr[$];
    logic [63:0] exp_wd[$];
    int kind_log[$];
    int cnt_log[$];

    int mon_phase = 0;   // 0 header, 1 message, 2 payload
    int mon_kind = 0;
    int mon_left = 0;
    int mon_dleft = 0;
    bit hold_pend = 1'b0;
    logic [63:0] hold_data = '0;

    always #2.5 clk = ~clk;

    req_packer #(.DEST_ID(4'd5)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_gran(rd_gran),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_gran(wr_gran),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data), .pkt_last(pkt_last));

    function automatic logic [63:0] mk_msg(input logic [39:0] a, input logic [3:0] g);
        return {20'd0, g, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (link_mode == 0)      pkt_ready = 1'b0;
        else if (link_mode == 1) pkt_ready = 1'b1;
        else                     pkt_ready = (($urandom % 10) < 7);
    end

    task automatic consume(input logic [63:0] w, input logic last);
        logic [63:0] e;
        if (mon_phase == 0) begin
            mon_kind = int'(w[1:0]);
            mon_left = int'(w[5:2]);
            chk(w[9:6] == 4'd5, "R6 dest", 64'(w[9:6]), 64'd5);
            chk(w[63:10] == '0, "R6 reserved", w, 64'd0);
            chk(mon_kind < 2, "R6 type", 64'(mon_kind), 64'd1);
            chk(mon_left >= 1 && mon_left <= 8, "R7 count range", 64'(mon_left), 64'd8);
            chk(!last, "R10 last on header", 64'(last), 64'd0);
            kind_log.push_back(mon_kind);
            cnt_log.push_back(mon_left);
            mon_phase = 1;
        end else if (mon_phase == 1) begin
            if (mon_kind == 1) begin
                chk(exp_wr.size() > 0, "R11 extra write", w, 64'd0);
                e = (exp_wr.size() > 0) ? exp_wr.pop_front() : 64'd0;
            end else begin
                chk(exp_rd.size() > 0, "R11 extra read", w, 64'd0);
                e = (exp_rd.size() > 0) ? exp_rd.pop_front() : 64'd0;
            end
            chk(w == e, "R8 R11 message", w, e);
            mon_left--;
            if (mon_kind == 1 && w[43:40] != 4'd0) begin
                mon_dleft = int'(w[43:40]);
                chk(!last, "R10 last before payload", 64'(last), 64'd0);
                mon_phase = 2;
            end else begin
                chk(last == (mon_left == 0), "R7 R10 last on message", 64'(last), 64'(mon_left == 0));
                if (mon_left == 0) mon_phase = 0;
            end
        end else begin
            chk(exp_wd.size() > 0, "R9 extra payload", w, 64'd0);
            e = (exp_wd.size() > 0) ? exp_wd.pop_front() : 64'd0;
            chk(w == e, "R9 payload", w, e);
            mon_dleft--;
            chk(last == (mon_dleft == 0 && mon_left == 0), "R10 last on payload",
                64'(last), 64'(mon_dleft == 0 && mon_left == 0));
            if (mon_dleft == 0) mon_phase = (mon_left == 0) ? 0 : 1;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend)
                chk(pkt_valid && pkt_data == hold_data, "R10 hold", pkt_data, hold_data);
            hold_pend = pkt_valid && !pkt_ready;
            hold_data = pkt_data;
            if (pkt_valid && pkt_ready) consume(pkt_data, pkt_last);
        end
    end

    task automatic push_wd(input logic [63:0] d);
        while (!wd_ready) @(negedge clk);
        wd_valid = 1'b1;
        wd_data  = d;
        exp_wd.push_back(d);
        @(negedge clk);
        wd_valid = 1'b0;
    endtask

    task automatic push_payload(input logic [3:0] g);
        for (int i = 0; i < int'(g); i++) push_wd({$urandom, $urandom});
    endtask

    task automatic push_req(input bit wr, input logic [39:0] a, input logic [3:0] g);
        if (wr) begin
            while (!wr_ready) @(negedge clk);
            wr_valid = 1'b1; wr_addr = a; wr_gran = g;
            exp_wr.push_back(mk_msg(a, g));
        end else begin
            while (!rd_ready) @(negedge clk);
            rd_valid = 1'b1; rd_addr = a; rd_gran = g;
            exp_rd.push_back(mk_msg(a, g));
        end
        @(negedge clk);
        rd_valid = 1'b0;
        wr_valid = 1'b0;
        if (wr) push_payload(g);
    endtask

    task automatic push_both(input logic [39:0] ra, input logic [3:0] rg,
                             input logic [39:0] wa, input logic [3:0] wg);
        while (!(rd_ready && wr_ready)) @(negedge clk);
        rd_valid = 1'b1; rd_addr = ra; rd_gran = rg;
        wr_valid = 1'b1; wr_addr = wa; wr_gran = wg;
        exp_rd.push_back(mk_msg(ra, rg));
        exp_wr.push_back(mk_msg(wa, wg));
        @(negedge clk);
        rd_valid = 1'b0;
        wr_valid = 1'b0;
        push_payload(wg);
    endtask

    task automatic drain_all();
        int guard = 0;
        link_mode = 1;
        while ((exp_rd.size() != 0 || exp_wr.size() != 0 || exp_wd.size() != 0 || mon_phase != 0)
               && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        chk(exp_rd.size() == 0, "R11 reads left", 64'(exp_rd.size()), 64'd0);
        chk(exp_wr.size() == 0, "R11 writes left", 64'(exp_wr.size()), 64'd0);
        chk(exp_wd.size() == 0, "R9 payload left", 64'(exp_wd.size()), 64'd0);
        chk(!pkt_valid, "R11 idle after drain", 64'(pkt_valid), 64'd0);
    endtask

    task automatic stall_and_clear();
        link_mode = 0;
        repeat (2) @(negedge clk);
        kind_log.delete();
        cnt_log.delete();
    endtask

    task automatic log_is(input int idx, input int k, input int c, input string req);
        chk(kind_log.size() > idx && kind_log[idx] == k, req,
            64'((kind_log.size() > idx) ? kind_log[idx] : -1), 64'(k));
        chk(cnt_log.size() > idx && cnt_log[idx] == c, req,
            64'((cnt_log.size() > idx) ? cnt_log[idx] : -1), 64'(c));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!pkt_valid, "R1 pkt_valid", 64'(pkt_valid), 64'd0);
        chk(rd_ready && wr_ready && wd_ready, "R1 readies",
            64'({rd_ready, wr_ready, wd_ready}), 64'd7);

        // R12 header prebuilt while link stalled
        stall_and_clear();
        push_req(1'b0, 40'h12_3456_789A, 4'd2);
        chk(!pkt_valid, "R12 not yet", 64'(pkt_valid), 64'd0);
        @(negedge clk);
        chk(pkt_valid && pkt_data == 64'h0000_0000_0000_0144, "R12 header ready",
            pkt_data, 64'h144);
        drain_all();
        log_is(0, 0, 1, "R12 packet");

        // R3 read priority below the watermark
        stall_and_clear();
        push_both(40'h100, 4'd1, 40'h200, 4'd2);
        for (int i = 0; i < 3; i++) push_req(1'b1, 40'h300 + 40'(i), 4'd1);
        for (int i = 0; i < 2; i++) push_req(1'b0, 40'h400 + 40'(i), 4'd3);
        drain_all();
        chk(kind_log.size() == 3, "R3 packet count", 64'(kind_log.size()), 64'd3);
        log_is(0, 0, 1, "R3 first read");
        log_is(1, 0, 2, "R3 second read");
        log_is(2, 1, 4, "R3 writes after reads");

        // R4 R5 drain hysteresis
        stall_and_clear();
        push_both(40'h1000, 4'd1, 40'h2000, 4'd1);
        for (int i = 0; i < 49; i++) push_req(1'b1, 40'h3000 + 40'(i), 4'd1);
        for (int i = 0; i < 5; i++) push_req(1'b0, 40'h5000 + 40'(i), 4'd0);
        drain_all();
        chk(kind_log.size() == 9, "R4 packet count", 64'(kind_log.size()), 64'd9);
        log_is(0, 0, 1, "R4 prebuilt read");
        for (int i = 1; i <= 5; i++) log_is(i, 1, 8, "R4 drain write");
        log_is(6, 0, 5, "R5 read resumes");
        log_is(7, 1, 8, "R5 remaining writes");
        log_is(8, 1, 2, "R5 final writes");

        // R2 queue depth and independence
        stall_and_clear();
        for (int i = 0; i < 64; i++) push_req(1'b0, 40'h8000 + 40'(i), 4'd1);
        chk(!rd_ready, "R2 read full", 64'(rd_ready), 64'd0);
        chk(wr_ready, "R2 write queue free", 64'(wr_ready), 64'd1);
        drain_all();
        chk(kind_log.size() == 9, "R7 cap packets", 64'(kind_log.size()), 64'd9);
        log_is(1, 0, 8, "R7 capped at max");
        log_is(8, 0, 7, "R7 tail packet");

        // random mix, R11 integrity under a stalling link
        stall_and_clear();
        link_mode = 2;
        for (int i = 0; i < 700; i++) begin
            int op = int'($urandom % 10);
            if (op < 5)      push_req(1'b0, {8'h0, $urandom}, 4'($urandom % 16));
            else if (op < 9) push_req(1'b1, {8'h0, $urandom}, 4'($urandom % 5));
            else             @(negedge clk);
        end
        drain_all();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule